// File: doc/BRIEF.md
# Scan-Delay Frame Decimator

This block sits between a sample source paced by one fixed conversion clock and a consumer that wants a slower scan rate. Samples arrive as frames of L channels each. The block groups the stream into chunks of (1+D) frames. It forwards the first frame of every chunk unchanged and quietly swallows the other D frames. The consumer therefore sees complete scans at 1/(1+D) of the frame rate, and the channel order inside each forwarded frame is kept.

A start pulse captures the configuration and arms the block. In counted mode the acquisition covers a set number of scans. Once the last sample of the last chunk has been consumed, the block raises a done flag. In continuous mode it runs until the next start. Whenever no acquisition is running, whether before the first start or after done, input is still taken every cycle and thrown away, so the source is never held up. The skip factor follows from the timing: D = scan period / (conversion period × L) − 1, and D = 0 passes every sample.

Top module: `scan_decimator`

## Requirements
- R1: After reset, out_valid and acq_done are 0 and in_ready is 1.
- R2: With a skip factor of 0, every sample accepted while running appears on the output in arrival order with its data unchanged.
- R3: With skip factor D, the stream splits into chunks of L·(1+D) accepted samples counted from start. Positions 0..L−1 of each chunk are forwarded and every other position is dropped.
- R4: In counted mode, acq_done goes to 1 in the cycle after the transfer that consumes sample number scans·L·(1+D). From that point out_valid is 0.
- R5: In continuous mode, acq_done stays 0 however many samples are consumed.
- R6: When not running (idle or done), in_ready is 1, out_valid is 0, and accepted samples are discarded.
- R7: A sample due for forwarding is accepted only together with out_ready (in_ready = out_ready). A sample due for dropping is accepted whatever out_ready is.
- R8: A start pulse, even during a run, puts the chunk position back to 0, reloads the scan budget and clears acq_done.
- R9: cfg_chans (L, 1 to 16), cfg_skip (D) and cfg_forever are captured at start. Changing them during a run has no effect on that run.
- R10: A start in counted mode with cfg_scans = 0 sets acq_done in the following cycle and forwards nothing.
- R11: When out_valid is 1, out_data equals in_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chans | input | 5 | Channels per frame L (1..16), captured at start |
| cfg_skip | input | 16 | Frames dropped after each kept frame, D |
| cfg_scans | input | 16 | Number of scans in counted mode |
| cfg_forever | input | 1 | 1 selects continuous mode |
| start | input | 1 | One-cycle pulse that arms an acquisition |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 16 | Input sample |
| out_valid | output | 1 | Forwarded sample valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 16 | Forwarded sample |
| acq_done | output | 1 | Counted acquisition finished |

## Verification
If the chunk position slips, the pattern of out_valid goes wrong straight away, on the next sample that should have been forwarded or dropped. A wrong frame or channel count moves the window by whole positions, and a per-cycle reference model sees this within one chunk. A budget that is off by one shows up as acq_done arriving one chunk early or late, or as extra forwarded samples after the expected end. A stale or uncleared position after a restart shows up on the first samples that follow the start pulse.

// File: rtl/scan_dec_pkg.sv
package scan_dec_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/sdec_position.sv
// Chunk position tracker: channel index inside a frame, frame index inside a chunk.
module sdec_position #(
  parameter int CH_W   = 5,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [CH_W-1:0]   lim_chan,
  input  logic [SKIP_W-1:0] lim_frame,
  output logic              keep,
  output logic              chunk_end
);
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [SKIP_W-1:0] frame_q, frame_d;
  logic              pos_en;

  assign pos_en = clr | adv;

  always_comb begin
    chan_d  = chan_q;
    frame_d = frame_q;
    if (clr) begin
      chan_d  = '0;
      frame_d = '0;
    end else if (adv) begin
      if (chan_q == lim_chan) begin
        chan_d  = '0;
        frame_d = (frame_q == lim_frame) ? '0 : frame_q + 1'b1;
      end else begin
        chan_d = chan_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      frame_q <= '0;
    end else if (pos_en) begin
      chan_q  <= chan_d;
      frame_q <= frame_d;
    end
  end

  assign keep      = (frame_q == '0);
  assign chunk_end = (chan_q == lim_chan) && (frame_q == lim_frame);

  // R8: a clear puts the position back to the chunk origin
  a_r8_clear_origin: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (chan_q == '0) && (frame_q == '0));
  // R3: position never walks past the captured frame limit while advancing
  a_r3_chan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && chunk_end) |=> (chan_q == '0) && (frame_q == '0));
endmodule

// File: rtl/sdec_budget.sv
// Scan budget: counts whole chunks left in a counted acquisition.
module sdec_budget #(
  parameter int SCAN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SCAN_W-1:0] load_val,
  input  logic              step,
  output logic              last
);
  logic [SCAN_W-1:0] rem_q, rem_d;
  logic              rem_en;

  assign rem_en = load | step;

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = load_val;
    else if (step) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign last = (rem_q == SCAN_W'(1));

  // R4: a chunk is never retired from an empty budget
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> (rem_q != '0));
  // R8: a load installs the requested scan count
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rem_q == $past(load_val)));
endmodule

// File: rtl/sdec_ctrl.sv
// Acquisition phase control and mode capture.
module sdec_ctrl
  import scan_dec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   cfg_forever,
  input  logic   cfg_zero,
  input  logic   adv,
  input  logic   chunk_end,
  input  logic   last,
  output phase_e phase,
  output logic   forever_q
);
  phase_e phase_q, phase_d;
  logic   fv_d;
  logic   finish;

  assign finish = (phase_q == PH_RUN) && adv && chunk_end && last && !forever_q;

  always_comb begin
    phase_d = phase_q;
    fv_d    = forever_q;
    if (start) begin
      fv_d    = cfg_forever;
      phase_d = (!cfg_forever && cfg_zero) ? PH_DONE : PH_RUN;
    end else if (finish) begin
      phase_d = PH_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      forever_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      forever_q <= fv_d;
    end
  end

  assign phase = phase_q;

  // R5: continuous runs never reach the done phase without a new start
  a_r5_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_RUN) && forever_q && !start) |=> (phase_q == PH_RUN));
  // R10: counted start with an empty budget finishes at once
  a_r10_zero_scans: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_forever && cfg_zero) |=> (phase_q == PH_DONE));
  // R8: done is left only through start
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_DONE) && !start) |=> (phase_q == PH_DONE));
endmodule

// File: rtl/scan_decimator.sv
module scan_decimator
  import scan_dec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_CHANS = 16,
  parameter int SKIP_W    = 16,
  parameter int SCAN_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [$clog2(MAX_CHANS+1)-1:0] cfg_chans,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [SCAN_W-1:0] cfg_scans,
  input  logic              cfg_forever,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              acq_done
);
  localparam int CH_W = $clog2(MAX_CHANS + 1);

  logic [CH_W-1:0]   lim_chan_q, lim_chan_d;
  logic [SKIP_W-1:0] lim_frame_q, lim_frame_d;
  logic              keep, chunk_end, last, forever_q;
  logic              running, pass_slot, adv, step;
  phase_e            phase;

  // configuration capture, enabled by start
  always_comb begin
    lim_chan_d  = cfg_chans - CH_W'(1);
    lim_frame_d = cfg_skip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_chan_q  <= '0;
      lim_frame_q <= '0;
    end else if (start) begin
      lim_chan_q  <= lim_chan_d;
      lim_frame_q <= lim_frame_d;
    end
  end

  assign running   = (phase == PH_RUN);
  assign pass_slot = running && keep;
  assign in_ready  = !pass_slot || out_ready;
  assign out_valid = in_valid && pass_slot;
  assign out_data  = in_data;
  assign acq_done  = (phase == PH_DONE);
  assign adv       = running && in_valid && in_ready;
  assign step      = adv && chunk_end && !forever_q;

  sdec_position #(.CH_W(CH_W), .SKIP_W(SKIP_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .adv       (adv),
    .lim_chan  (lim_chan_q),
    .lim_frame (lim_frame_q),
    .keep      (keep),
    .chunk_end (chunk_end)
  );

  sdec_budget #(.SCAN_W(SCAN_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (cfg_scans),
    .step     (step),
    .last     (last)
  );

  sdec_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_forever (cfg_forever),
    .cfg_zero    (cfg_scans == '0),
    .adv         (adv),
    .chunk_end   (chunk_end),
    .last        (last),
    .phase       (phase),
    .forever_q   (forever_q)
  );

  // R7: a forwarded sample is never taken without the consumer
  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R6: outside a run nothing is forwarded and the source is never stalled
  a_r6_quiet_sink: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> (!out_valid && in_ready));
  // R4: the done flag only rises from a run or a start
  a_r4_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_done) |-> ($past(running) || $past(start)));
endmodule

// File: tb/tb_scan_decimator.sv
module tb_scan_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n;
  logic [4:0]  cfg_chans;
  logic [15:0] cfg_skip, cfg_scans;
  logic        cfg_forever, start;
  logic        in_valid, in_ready, out_valid, out_ready, acq_done;
  logic [15:0] in_data, out_data;

  int n_vec, n_bad, fwd, cyc;
  // reference model state
  int m_L, m_D, m_phase, m_pos;
  longint m_rem;
  bit m_fv;
  bit finished;

  scan_decimator dut (
    .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans), .cfg_skip(cfg_skip),
    .cfg_scans(cfg_scans), .cfg_forever(cfg_forever), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .acq_done(acq_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the behavioural model, then model step
  always @(negedge clk) begin
    if (rst_n) begin
      bit run, kp, e_ov, e_ir, fire;
      run  = (m_phase == 1);
      kp   = (m_pos < m_L);
      e_ov = in_valid && run && kp;
      e_ir = !(run && kp) || out_ready;
      chk("R3/R6 out_valid", out_valid, e_ov);
      chk("R7 in_ready", in_ready, e_ir);
      chk("R4/R5 acq_done", acq_done, m_phase == 2);
      if (e_ov) chk("R11 out_data", out_data, in_data);
      fire = in_valid && e_ir;
      if (e_ov && out_ready) fwd++;
      if (fire && run) begin
        m_pos = (m_pos + 1) % (m_L * (1 + m_D));
        if (!m_fv) begin
          m_rem--;
          if (m_rem == 0) m_phase = 2;
        end
      end
      if (start) begin
        m_L = int'(cfg_chans); m_D = int'(cfg_skip); m_fv = cfg_forever;
        m_pos = 0;
        m_rem = longint'(cfg_scans) * m_L * (1 + m_D);
        m_phase = (!cfg_forever && cfg_scans == 0) ? 2 : 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL R4 watchdog expired act=%0d exp<=%0d", cyc, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic do_start(input int L, input int D, input int S, input bit fv);
    @(posedge clk); #1;
    cfg_chans = 5'(L); cfg_skip = 16'(D); cfg_scans = 16'(S); cfg_forever = fv;
    start = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic stream(input int n, input int pv, input int pr, input bit stop_on_done);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid  = ($urandom_range(99) < pv);
      out_ready = ($urandom_range(99) < pr);
      in_data   = 16'($urandom);
      if (stop_on_done && acq_done) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; fwd = 0; cyc = 0; finished = 0;
    m_L = 1; m_D = 0; m_phase = 0; m_pos = 0; m_rem = 0; m_fv = 0;
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; cfg_chans = 5'd1; cfg_skip = '0; cfg_scans = '0; cfg_forever = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 acq_done after reset", acq_done, 0);
    chk("R1 in_ready after reset", in_ready, 1);

    // R6: idle sink discards
    out_ready = 1'b0;
    stream(20, 100, 0, 0);

    // R2: no skipping, full flow
    fwd = 0;
    do_start(4, 0, 3, 0);
    stream(100, 100, 100, 1);
    chk("R4 done after counted run", acq_done, 1);
    chk("R2 forwarded count", fwd, 12);

    // R3/R7: skipping under random handshakes
    fwd = 0;
    do_start(3, 2, 2, 0);
    stream(2000, 60, 50, 1);
    chk("R4 done after skip run", acq_done, 1);
    chk("R3 forwarded count", fwd, 6);

    // R6: input after done is discarded
    fwd = 0;
    stream(50, 100, 100, 0);
    chk("R6 nothing forwarded after done", fwd, 0);
    chk("R6 done stays", acq_done, 1);

    // R5: continuous mode
    do_start(1, 5, 1, 1);
    stream(300, 80, 70, 0);
    chk("R5 continuous never done", acq_done, 0);

    // R9: config changes mid-run ignored; R8: restart mid-run
    fwd = 0;
    do_start(2, 1, 3, 0);
    cfg_chans = 5'd5; cfg_skip = 16'd0; cfg_forever = 1'b1;
    stream(7, 100, 100, 0);
    do_start(16, 1, 2, 0);
    fwd = 0;
    stream(400, 90, 90, 1);
    chk("R8 restarted run done", acq_done, 1);
    chk("R8 forwarded after restart", fwd, 32);

    // R10: zero scans in counted mode
    fwd = 0;
    do_start(3, 0, 0, 0);
    @(negedge clk);
    chk("R10 zero scans done", acq_done, 1);
    stream(20, 100, 100, 0);
    chk("R10 nothing forwarded", fwd, 0);

    // R8: start clears done
    do_start(1, 0, 4, 0);
    @(negedge clk);
    chk("R8 done cleared by start", acq_done, 0);
    stream(100, 100, 100, 1);
    chk("R4 done after single-channel run", acq_done, 1);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule